// File: doc/BRIEF.md
# Pipelined Multiplier for a Compact Floating-Point Format

This block multiplies two numbers in a compact floating-point format. Each number has a sign bit, an exponent stored as a two's-complement integer, and an unsigned mantissa. The mantissa is a fraction in [0.5, 1), so its top bit is stored explicitly; there is no hidden bit. The value is (-1)^sign · 2^exponent · mantissa/2^MANT_W. The widths are parameters. By default the mantissa is 16 bits and the exponent is 8 bits.

A caller drives both operands and raises `req_i` for one cycle. Three register stages follow:

- capturing the operands;
- forming the sign, the exponent sum and the double-width mantissa product;
- normalizing.

The block raises `ready_o` for one cycle when the result is valid on the result ports. A new request may be issued on every cycle.

The block does not handle infinities, NaNs or subnormals. It has no rounding and no overflow flag. Exponent arithmetic wraps modulo 2^EXP_W, and the mantissa is truncated.

Top module: `fmul_pipe`

## Requirements
- R1: If `req_i` is high at rising edge k, then `ready_o` is high for exactly the cycle that follows rising edge k+2. The result ports hold the matching result during that cycle.
- R2: The result sign is the XOR of the two operand signs, including when the result is zero.
- R3: The result exponent is the sum of the operand exponents minus the normalization shift count. The arithmetic wraps modulo 2^EXP_W.
- R4: The full 2·MANT_W-bit product of the mantissas is formed. Only its upper MANT_W bits are kept before normalization, and the lower bits are discarded without rounding.
- R5: When the kept upper half is nonzero, the mantissa is shifted left until bit MANT_W-1 is 1. The shift count is subtracted from the exponent, and zeros fill in from the right.
- R6: When the kept upper half is zero, the result mantissa and the result exponent are both zero.
- R7: Requests on consecutive cycles each produce their own one-cycle `ready_o` pulse and their own result, three cycles later and in request order. No `ready_o` pulse appears without a request.
- R8: While `rst_ni` is low, `ready_o` and all result ports are zero.
- R9: Operand inputs are ignored in cycles where `req_i` is low. Changing them does not alter any result already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Load operands and start a multiplication |
| a_sign_i | input | 1 | Sign of operand A (1 = negative) |
| a_exp_i | input | EXP_W | Exponent of operand A, two's complement |
| a_mant_i | input | MANT_W | Mantissa of operand A, unsigned fraction |
| b_sign_i | input | 1 | Sign of operand B |
| b_exp_i | input | EXP_W | Exponent of operand B, two's complement |
| b_mant_i | input | MANT_W | Mantissa of operand B |
| ready_o | output | 1 | One-cycle pulse: result valid |
| res_sign_o | output | 1 | Result sign |
| res_exp_o | output | EXP_W | Result exponent, two's complement |
| res_mant_o | output | MANT_W | Result mantissa, normalized or zero |

## Verification
With normalized operands, the upper half of the product is never smaller than one quarter. A normal run therefore only ever produces a normalization shift of zero or one.

Large shifts and the all-zero result only appear when an operand is fed that breaks the format. The stimulus reaches them with directed operands:

- mantissas with many leading zeros, such as 0x0100 · 0x0100, which needs a 15-bit shift;
- tiny mantissas whose product falls entirely into the discarded half;
- a zero mantissa.

These are mixed into seeded random traffic. That traffic issues back-to-back requests and scrambles the operand inputs while `req_i` is low. This exercises overlapping results and the rule that operands are ignored without a request.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  // register stages between request and result: capture, multiply, normalize
  localparam int unsigned FMUL_STAGES = 3;
endpackage

// File: rtl/fmul_lzc.sv
module fmul_lzc #(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    // the highest set bit is visited last and wins
    for (int i = 0; i < int'(W); i++) begin
      if (vec_i[i]) cnt_o = CW'(int'(W) - 1 - i);
    end
  end
endmodule

// File: rtl/fmul_norm.sv
module fmul_norm #(
  parameter int unsigned MANT_W = 16,
  parameter int unsigned EXP_W  = 8
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [MANT_W-1:0] mant_o,
  output logic [EXP_W-1:0]  exp_o
);
  localparam int unsigned CW = $clog2(MANT_W + 1);

  logic [CW-1:0] lz;

  fmul_lzc #(.W(MANT_W)) u_lzc (
    .vec_i (mant_i),
    .cnt_o (lz)
  );

  always_comb begin
    if (mant_i == '0) begin
      mant_o = '0;
      exp_o  = '0;
    end else begin
      mant_o = mant_i << lz;
      exp_o  = exp_i - EXP_W'(lz);
    end
  end
endmodule

// File: rtl/fmul_ready_pipe.sv
module fmul_ready_pipe
  import fmul_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic ready_o
);
  logic [FMUL_STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[FMUL_STAGES-2:0], req_i};
  end

  assign ready_o = sr_q[FMUL_STAGES-1];

  p_ready_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> ##3 ready_o);

  p_no_spurious_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(req_i, 3));
endmodule

// File: rtl/fmul_pipe.sv
module fmul_pipe #(
  parameter int unsigned MANT_W = 16,
  parameter int unsigned EXP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              a_sign_i,
  input  logic [EXP_W-1:0]  a_exp_i,
  input  logic [MANT_W-1:0] a_mant_i,
  input  logic              b_sign_i,
  input  logic [EXP_W-1:0]  b_exp_i,
  input  logic [MANT_W-1:0] b_mant_i,
  output logic              ready_o,
  output logic              res_sign_o,
  output logic [EXP_W-1:0]  res_exp_o,
  output logic [MANT_W-1:0] res_mant_o
);
  localparam int unsigned PW = 2 * MANT_W;

  // stage 1: operand capture
  logic              a_sign_q, b_sign_q;
  logic [EXP_W-1:0]  a_exp_q, b_exp_q;
  logic [MANT_W-1:0] a_mant_q, b_mant_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sign_q <= 1'b0;
      b_sign_q <= 1'b0;
      a_exp_q  <= '0;
      b_exp_q  <= '0;
      a_mant_q <= '0;
      b_mant_q <= '0;
    end else if (req_i) begin
      a_sign_q <= a_sign_i;
      b_sign_q <= b_sign_i;
      a_exp_q  <= a_exp_i;
      b_exp_q  <= b_exp_i;
      a_mant_q <= a_mant_i;
      b_mant_q <= b_mant_i;
    end
  end

  // stage 2: sign, exponent sum, full-width product
  logic              sign_q;
  logic [EXP_W-1:0]  exp_sum_q;
  logic [PW-1:0]     prod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sign_q    <= 1'b0;
      exp_sum_q <= '0;
      prod_q    <= '0;
    end else begin
      sign_q    <= a_sign_q ^ b_sign_q;
      exp_sum_q <= a_exp_q + b_exp_q;
      prod_q    <= PW'(a_mant_q) * PW'(b_mant_q);
    end
  end

  // stage 3: truncate to upper half, normalize
  logic [MANT_W-1:0] norm_mant;
  logic [EXP_W-1:0]  norm_exp;

  fmul_norm #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_norm (
    .mant_i (prod_q[PW-1:MANT_W]),
    .exp_i  (exp_sum_q),
    .mant_o (norm_mant),
    .exp_o  (norm_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_sign_o <= 1'b0;
      res_exp_o  <= '0;
      res_mant_o <= '0;
    end else begin
      res_sign_o <= sign_q;
      res_exp_o  <= norm_exp;
      res_mant_o <= norm_mant;
    end
  end

  fmul_ready_pipe u_ready (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .ready_o (ready_o)
  );

  p_sign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> res_sign_o == ($past(a_sign_i, 3) ^ $past(b_sign_i, 3)));

  p_norm_msb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && res_mant_o != '0) |-> res_mant_o[MANT_W-1]);

  p_zero_exp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && res_mant_o == '0) |-> res_exp_o == '0);
endmodule

// File: tb/fmul_pipe_bench.sv
module fmul_pipe_bench;
  localparam int MW = 16;
  localparam int EW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          a_s = 1'b0, b_s = 1'b0;
  logic [EW-1:0] a_e = '0, b_e = '0;
  logic [MW-1:0] a_m = '0, b_m = '0;
  logic          rdy, r_s;
  logic [EW-1:0] r_e;
  logic [MW-1:0] r_m;

  always #2.5 clk = ~clk;

  fmul_pipe #(.MANT_W(MW), .EXP_W(EW)) u_fmul_pipe (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .a_sign_i(a_s), .a_exp_i(a_e), .a_mant_i(a_m),
    .b_sign_i(b_s), .b_exp_i(b_e), .b_mant_i(b_m),
    .ready_o(rdy), .res_sign_o(r_s), .res_exp_o(r_e), .res_mant_o(r_m)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // expected result: {sign, exp, mant}
  function automatic logic [1+EW+MW-1:0] model(
    input logic sa, input logic [EW-1:0] ea, input logic [MW-1:0] ma,
    input logic sb, input logic [EW-1:0] eb, input logic [MW-1:0] mb);
    logic [2*MW-1:0] p;
    logic [MW-1:0]   h;
    logic [EW-1:0]   e;
    p = (2*MW)'(ma) * (2*MW)'(mb);
    h = p[2*MW-1:MW];          // R4 truncation
    e = ea + eb;               // R3
    if (h == '0) return {sa ^ sb, {EW{1'b0}}, {MW{1'b0}}};  // R6
    while (!h[MW-1]) begin     // R5
      h = h << 1;
      e = e - 1'b1;
    end
    return {sa ^ sb, e, h};
  endfunction

  task automatic chk(input string req_tag, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp_v);
    end
  endtask

  // pending expected results
  logic [1+EW+MW-1:0] q_val [16];
  int                 q_due [16];
  string              q_tag [16];
  int                 q_hd = 0, q_tl = 0;

  int cyc = 0;

  task automatic check_outputs();
    if (q_hd != q_tl && q_due[q_hd] == cyc) begin
      chk("R1/R7 ready", 64'(rdy), 64'd1);
      chk({q_tag[q_hd], " R2 sign"}, 64'(r_s), 64'(q_val[q_hd][EW+MW]));
      chk({q_tag[q_hd], " R3 exp"}, 64'(r_e), 64'(q_val[q_hd][EW+MW-1:MW]));
      chk({q_tag[q_hd], " R4/R5 mant"}, 64'(r_m), 64'(q_val[q_hd][MW-1:0]));
      q_hd = (q_hd + 1) % 16;
    end else begin
      chk("R7 no spurious ready", 64'(rdy), 64'd0);
    end
  endtask

  task automatic drive_req(input string tag,
    input logic sa, input logic [EW-1:0] ea, input logic [MW-1:0] ma,
    input logic sb, input logic [EW-1:0] eb, input logic [MW-1:0] mb);
    req = 1'b1;
    a_s = sa; a_e = ea; a_m = ma;
    b_s = sb; b_e = eb; b_m = mb;
    q_val[q_tl] = model(sa, ea, ma, sb, eb, mb);
    q_due[q_tl] = cyc + 3;
    q_tag[q_tl] = tag;
    q_tl = (q_tl + 1) % 16;
  endtask

  task automatic drive_idle();
    // R9: scramble operands while no request
    req = 1'b0;
    a_s = 1'($urandom); b_s = 1'($urandom);
    a_e = EW'($urandom); b_e = EW'($urandom);
    a_m = MW'($urandom); b_m = MW'($urandom);
  endtask

  function automatic logic [EW-1:0] rnd_exp();
    return EW'(int'($urandom_range(120)) - 60);
  endfunction

  function automatic logic [MW-1:0] rnd_mant();
    return MW'($urandom) | {1'b1, {(MW-1){1'b0}}};
  endfunction

  task automatic step();
    @(negedge clk);
    check_outputs();
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 ready", 64'(rdy), 64'd0);
    chk("R8 sign", 64'(r_s), 64'd0);
    chk("R8 exp", 64'(r_e), 64'd0);
    chk("R8 mant", 64'(r_m), 64'd0);
    rst_n = 1'b1;

    // directed corners, back to back (R7)
    step(); drive_req("R5 half*half", 1'b0, 8'd3, 16'h8000, 1'b1, 8'hFE, 16'h8000);
    cyc++; step(); drive_req("R4 max*max", 1'b1, 8'd10, 16'hFFFF, 1'b1, 8'd5, 16'hFFFF);
    cyc++; step(); drive_req("R5 big shift", 1'b0, 8'd0, 16'h0100, 1'b0, 8'd0, 16'h0100);
    cyc++; step(); drive_req("R6 tiny", 1'b1, 8'd7, 16'h0001, 1'b0, 8'd9, 16'h00FF);
    cyc++; step(); drive_req("R6 zero", 1'b1, 8'd20, 16'h0000, 1'b0, 8'd3, 16'hC000);
    cyc++; step(); drive_req("R3 min exp", 1'b0, 8'hC0, 16'hA000, 1'b0, 8'hC0, 16'hC000);
    cyc++; step(); drive_idle();
    cyc++; step(); drive_idle();
    cyc++; step(); drive_req("R3 max exp", 1'b1, 8'd63, 16'hFFFF, 1'b0, 8'd63, 16'h8001);
    cyc++;

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      step();
      if ($urandom_range(9) < 6)
        drive_req("R2/R3 random", 1'($urandom), rnd_exp(), rnd_mant(),
                  1'($urandom), rnd_exp(), rnd_mant());
      else
        drive_idle();
      cyc++;
    end
    // drain
    for (int i = 0; i < 5; i++) begin
      step(); drive_idle(); cyc++;
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule